// File: doc/BRIEF.md
# Flash Block Write-Protection Walker

This block holds the write-protection state of every erase block in a flash array. Each block is in one of three states: open for writing (unlocked), closed but reopenable (locked), or closed until the next cold reset (lock-tight). The host loads a first-block and a last-block register and then issues a command code. The block steps through the selected blocks one per clock cycle and applies the command's target state. A walk stops early at a lock-tight block or at an index past the end of the array.

At the end of every walk the block gives a one-cycle completion pulse, which the interrupt and status logic uses as the master interrupt. An error flag comes with that pulse when the walk ran past the array. A status register holds the last state written. A combinational query port returns the state of any one block. Enforcing protection on program and erase operations is left to the logic that consumes these states.

Top module: `blk_lock_mgr`

## Requirements
- R1: After a cold reset every block is locked, the status register reads 0x0002, both range registers read 0, and `cmd_ready` is high.
- R2: A write to the first-block register stores the low IDX_W bits of `wdata` (6 bits at the default 48 blocks) and copies the same value into the last-block register. A write to the last-block register alone changes only the last block.
- R3: Code 0x23 sets blocks first..last (inclusive, ascending) to unlocked. It stops without change at the first lock-tight block.
- R4: Code 0x2A sets blocks first..last to locked, with the same stop rule as R3.
- R5: Code 0x2C walks first..last. It leaves unlocked blocks untouched and continues past them. Every other block in the range becomes lock-tight.
- R6: Code 0x27 walks from block 0 to block NUM_BLOCKS-1, unlocking each block, with the stop rule of R3.
- R7: When a walk reaches an index of NUM_BLOCKS or more, it stops and `cmd_err` is high together with `done`. Blocks visited before that point keep their new states.
- R8: When first > last, a range command changes no block, raises `done` and does not set `cmd_err`.
- R9: Each block write also loads its new state into `wp_status`, zero-extended. The states are one-hot: bit 0 is lock-tight, bit 1 is locked, bit 2 is unlocked.
- R10: A command is accepted on the edge where `cmd_valid` and `cmd_ready` are both high. Each walk cycle evaluates one block. `done` is high for exactly one cycle, k cycles after the accept edge, where k is the number of evaluations including the one that ends the walk. `cmd_ready` is low during the walk.
- R11: Commands presented while a walk is running are ignored, and so are codes other than the four above.
- R12: `q_state` returns the one-hot state of block `q_idx`, or 0 when `q_idx` is NUM_BLOCKS or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low cold reset |
| start_wr | input | 1 | Write `wdata` to the first-block register (and the last-block register) |
| end_wr | input | 1 | Write `wdata` to the last-block register |
| wdata | input | 16 | Register write data |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 8 | Command code |
| cmd_ready | output | 1 | High when no walk is running |
| start_blk | output | IDX_W | First-block register |
| end_blk | output | IDX_W | Last-block register |
| wp_status | output | 16 | Last state written by a walk |
| done | output | 1 | One-cycle end-of-walk pulse (master interrupt) |
| cmd_err | output | 1 | Walk ran past the array; valid with `done` |
| q_idx | input | IDX_W | Block index to query |
| q_state | output | 3 | One-hot state of block `q_idx` |

## Verification
Range register writes appear on the edge that samples the strobe, so the bench reads them at the following falling edge. The bench's reference walk counts k, the number of block evaluations a command needs, including the terminating one. It then counts clock edges from the accept edge until `done` is seen, and requires that count to equal k. `cmd_ready` must be low at the first falling edge after the accept, and `done` must be low again one cycle after it rises. Block states, `wp_status` and `cmd_err` are compared only once the walk has finished, and a competing command is injected at the second walk cycle, when the walker is known to be busy.

// File: rtl/blk_lock_pkg.sv
package blk_lock_pkg;

    // One-hot protection state of a single erase block
    typedef enum logic [2:0] {
        LS_TIGHT    = 3'b001,
        LS_LOCKED   = 3'b010,
        LS_UNLOCKED = 3'b100
    } lock_st_t;

    // Internal walk operation selected by the decoder
    typedef enum logic [2:0] {
        OP_NONE       = 3'd0,
        OP_UNLOCK     = 3'd1,
        OP_UNLOCK_ALL = 3'd2,
        OP_LOCK       = 3'd3,
        OP_TIGHT      = 3'd4
    } walk_op_t;

    localparam logic [7:0]  CODE_UNLOCK     = 8'h23;
    localparam logic [7:0]  CODE_UNLOCK_ALL = 8'h27;
    localparam logic [7:0]  CODE_LOCK       = 8'h2A;
    localparam logic [7:0]  CODE_TIGHT      = 8'h2C;

    localparam int          WP_W     = 16;
    localparam logic [15:0] WP_RESET = 16'h0002;

endpackage

// File: rtl/blk_lock_range_regs.sv
module blk_lock_range_regs #(
    parameter int IDX_W  = 6,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_wr,
    input  logic              end_wr,
    input  logic [DATA_W-1:0] wdata,
    output logic [IDX_W-1:0]  start_q,
    output logic [IDX_W-1:0]  end_q
);

    typedef struct packed {
        logic [IDX_W-1:0] first;
        logic [IDX_W-1:0] last;
    } rng_t;

    rng_t rng_d, rng_q;

    always_comb begin
        rng_d = rng_q;
        if (start_wr) begin
            // the first-block write also seeds the last block
            rng_d.first = wdata[IDX_W-1:0];
            rng_d.last  = wdata[IDX_W-1:0];
        end
        if (end_wr) begin
            rng_d.last = wdata[IDX_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) rng_q <= '0;
        else        rng_q <= rng_d;
    end

    assign start_q = rng_q.first;
    assign end_q   = rng_q.last;

endmodule

// File: rtl/blk_lock_decode.sv
module blk_lock_decode
    import blk_lock_pkg::*;
(
    input  logic [7:0] code,
    output walk_op_t   op
);

    always_comb begin
        case (code)
            CODE_UNLOCK:     op = OP_UNLOCK;
            CODE_UNLOCK_ALL: op = OP_UNLOCK_ALL;
            CODE_LOCK:       op = OP_LOCK;
            CODE_TIGHT:      op = OP_TIGHT;
            default:         op = OP_NONE;
        endcase
    end

endmodule

// File: rtl/blk_lock_state_array.sv
module blk_lock_state_array
    import blk_lock_pkg::*;
#(
    parameter int NUM_BLOCKS = 48,
    parameter int IDX_W      = 6,
    localparam int CW        = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [CW-1:0]    wr_idx,
    input  logic [2:0]       wr_state,
    input  logic [CW-1:0]    walk_idx,
    output logic [2:0]       walk_state,
    input  logic [IDX_W-1:0] q_idx,
    output logic [2:0]       q_state
);

    logic [2:0] blk_st [NUM_BLOCKS];

    for (genvar i = 0; i < NUM_BLOCKS; i++) begin : g_blk
        logic [2:0] st_d, st_q;

        always_comb begin
            st_d = st_q;
            if (wr_en && (wr_idx == CW'(i))) st_d = wr_state;
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) st_q <= LS_LOCKED;
            else        st_q <= st_d;
        end

        assign blk_st[i] = st_q;
    end

    // Read ports: an index outside the array yields no state bits
    always_comb begin
        walk_state = '0;
        q_state    = '0;
        for (int i = 0; i < NUM_BLOCKS; i++) begin
            if (walk_idx == CW'(i))        walk_state = blk_st[i];
            if ({1'b0, q_idx} == CW'(i))   q_state    = blk_st[i];
        end
    end

endmodule

// File: rtl/blk_lock_walker.sv
module blk_lock_walker
    import blk_lock_pkg::*;
#(
    parameter int NUM_BLOCKS = 48,
    parameter int IDX_W      = 6,
    localparam int CW        = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  walk_op_t         op_in,
    input  logic [IDX_W-1:0] first_idx,
    input  logic [IDX_W-1:0] last_idx,
    input  logic [2:0]       cur_state,
    output logic [CW-1:0]    cur_idx,
    output logic             wr_en,
    output logic [2:0]       wr_state,
    output logic             busy,
    output logic             done,
    output logic             err
);

    localparam logic [CW-1:0] LIMIT    = CW'(NUM_BLOCKS);
    localparam logic [CW-1:0] TOP_IDX  = CW'(NUM_BLOCKS - 1);

    typedef struct packed {
        logic          busy;
        walk_op_t      op;
        logic [CW-1:0] cur;
        logic [CW-1:0] last;
        logic          done;
        logic          err;
    } walk_t;

    walk_t w_d, w_q;
    logic  tight_here;

    always_comb begin
        case (w_q.op)
            OP_UNLOCK, OP_UNLOCK_ALL: wr_state = LS_UNLOCKED;
            OP_LOCK:                  wr_state = LS_LOCKED;
            default:                  wr_state = LS_TIGHT;
        endcase
    end

    assign tight_here = (cur_state == LS_TIGHT);

    always_comb begin
        w_d      = w_q;
        w_d.done = 1'b0;
        w_d.err  = 1'b0;
        wr_en    = 1'b0;
        if (!w_q.busy) begin
            if (go && op_in != OP_NONE) begin
                w_d.busy = 1'b1;
                w_d.op   = op_in;
                w_d.cur  = (op_in == OP_UNLOCK_ALL) ? '0 : {1'b0, first_idx};
                w_d.last = (op_in == OP_UNLOCK_ALL) ? TOP_IDX : {1'b0, last_idx};
            end
        end else if (w_q.cur > w_q.last) begin
            // empty range
            w_d.busy = 1'b0;
            w_d.done = 1'b1;
            w_d.op   = OP_NONE;
        end else if (w_q.cur >= LIMIT) begin
            w_d.busy = 1'b0;
            w_d.done = 1'b1;
            w_d.err  = 1'b1;
            w_d.op   = OP_NONE;
        end else if (tight_here && w_q.op != OP_TIGHT) begin
            w_d.busy = 1'b0;
            w_d.done = 1'b1;
            w_d.op   = OP_NONE;
        end else begin
            wr_en = !(w_q.op == OP_TIGHT && cur_state == LS_UNLOCKED);
            if (w_q.cur == w_q.last) begin
                w_d.busy = 1'b0;
                w_d.done = 1'b1;
                w_d.op   = OP_NONE;
            end else begin
                w_d.cur = w_q.cur + CW'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '{busy: 1'b0, op: OP_NONE, cur: '0, last: '0, done: 1'b0, err: 1'b0};
        else        w_q <= w_d;
    end

    assign cur_idx = w_q.cur;
    assign busy    = w_q.busy;
    assign done    = w_q.done;
    assign err     = w_q.err;

endmodule

// File: rtl/blk_lock_mgr.sv
module blk_lock_mgr
    import blk_lock_pkg::*;
#(
    parameter int NUM_BLOCKS = 48,
    localparam int IDX_W     = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_wr,
    input  logic             end_wr,
    input  logic [15:0]      wdata,
    input  logic             cmd_valid,
    input  logic [7:0]       cmd_code,
    output logic             cmd_ready,
    output logic [IDX_W-1:0] start_blk,
    output logic [IDX_W-1:0] end_blk,
    output logic [15:0]      wp_status,
    output logic             done,
    output logic             cmd_err,
    input  logic [IDX_W-1:0] q_idx,
    output logic [2:0]       q_state
);

    localparam int CW = IDX_W + 1;

    walk_op_t      dec_op;
    logic [CW-1:0] walk_idx;
    logic [2:0]    walk_state;
    logic          wr_en;
    logic [2:0]    wr_state;
    logic          busy;
    logic [WP_W-1:0] wp_d, wp_q;

    blk_lock_range_regs #(.IDX_W(IDX_W), .DATA_W(16)) u_rng (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_wr (start_wr),
        .end_wr   (end_wr),
        .wdata    (wdata),
        .start_q  (start_blk),
        .end_q    (end_blk)
    );

    blk_lock_decode u_dec (
        .code (cmd_code),
        .op   (dec_op)
    );

    blk_lock_walker #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W)) u_walk (
        .clk       (clk),
        .rst_n     (rst_n),
        .go        (cmd_valid),
        .op_in     (dec_op),
        .first_idx (start_blk),
        .last_idx  (end_blk),
        .cur_state (walk_state),
        .cur_idx   (walk_idx),
        .wr_en     (wr_en),
        .wr_state  (wr_state),
        .busy      (busy),
        .done      (done),
        .err       (cmd_err)
    );

    blk_lock_state_array #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W)) u_arr (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_idx     (walk_idx),
        .wr_state   (wr_state),
        .walk_idx   (walk_idx),
        .walk_state (walk_state),
        .q_idx      (q_idx),
        .q_state    (q_state)
    );

    // status register: mirrors the most recent block write
    always_comb begin
        wp_d = wp_q;
        if (wr_en) wp_d = {{(WP_W-3){1'b0}}, wr_state};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wp_q <= WP_RESET;
        else        wp_q <= wp_d;
    end

    assign wp_status = wp_q;
    assign cmd_ready = !busy;

endmodule

// File: rtl/blk_lock_mgr_chk.sv
module blk_lock_mgr_chk #(
    parameter int NUM_BLOCKS = 48,
    parameter int IDX_W      = 6
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_wr,
    input logic             end_wr,
    input logic [15:0]      wdata,
    input logic             cmd_valid,
    input logic [7:0]       cmd_code,
    input logic             cmd_ready,
    input logic [IDX_W-1:0] start_blk,
    input logic [IDX_W-1:0] end_blk,
    input logic [15:0]      wp_status,
    input logic             done,
    input logic             cmd_err,
    input logic [IDX_W-1:0] q_idx,
    input logic [2:0]       q_state
);

    logic known_code;
    assign known_code = (cmd_code == 8'h23) || (cmd_code == 8'h27) ||
                        (cmd_code == 8'h2A) || (cmd_code == 8'h2C);

    assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_ends_walk_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (cmd_ready && !$past(cmd_ready)));

    assert_err_with_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_err |-> done);

    assert_wp_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot(wp_status[2:0]) && (wp_status[15:3] == 13'd0));

    assert_start_copies_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start_wr |=> (end_blk == start_blk) && (start_blk == $past(wdata[IDX_W-1:0])));

    assert_end_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (end_wr && !start_wr) |=> $stable(start_blk));

    assert_accept_only_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cmd_ready) |-> ($past(cmd_valid) && $past(known_code)));

    assert_query_onehot_R12: assert property (@(posedge clk) disable iff (!rst_n)
        ({1'b0, q_idx} < (IDX_W+1)'(NUM_BLOCKS)) |-> $onehot(q_state));

endmodule

bind blk_lock_mgr blk_lock_mgr_chk #(.NUM_BLOCKS(NUM_BLOCKS), .IDX_W(IDX_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_wr  (start_wr),
    .end_wr    (end_wr),
    .wdata     (wdata),
    .cmd_valid (cmd_valid),
    .cmd_code  (cmd_code),
    .cmd_ready (cmd_ready),
    .start_blk (start_blk),
    .end_blk   (end_blk),
    .wp_status (wp_status),
    .done      (done),
    .cmd_err   (cmd_err),
    .q_idx     (q_idx),
    .q_state   (q_state)
);

// File: tb/blk_lock_mgr_tb.sv
module blk_lock_mgr_tb;
    import blk_lock_pkg::*;

    localparam int NB = 48;
    localparam int IW = 6;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start_wr, end_wr;
    logic [15:0]   wdata;
    logic          cmd_valid;
    logic [7:0]    cmd_code;
    logic          cmd_ready;
    logic [IW-1:0] start_blk, end_blk;
    logic [15:0]   wp_status;
    logic          done, cmd_err;
    logic [IW-1:0] q_idx;
    logic [2:0]    q_state;

    always #4 clk = ~clk;

    blk_lock_mgr #(.NUM_BLOCKS(NB)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_wr(start_wr), .end_wr(end_wr),
        .wdata(wdata), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_ready(cmd_ready), .start_blk(start_blk), .end_blk(end_blk),
        .wp_status(wp_status), .done(done), .cmd_err(cmd_err),
        .q_idx(q_idx), .q_state(q_state)
    );

    int   n_chk = 0;
    int   n_fail = 0;
    bit   finished = 0;
    logic [2:0] exp_st [NB];
    int   exp_start, exp_end, exp_wp, exp_k;
    bit   exp_err;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [2:0] tgt_of(input logic [7:0] c);
        case (c)
            CODE_UNLOCK, CODE_UNLOCK_ALL: return LS_UNLOCKED;
            CODE_LOCK:                    return LS_LOCKED;
            default:                      return LS_TIGHT;
        endcase
    endfunction

    // Reference walk from the requirements: R3..R9
    task automatic model_run(input logic [7:0] code);
        int first;
        int last;
        int b;
        logic [2:0] t;
        t     = tgt_of(code);
        first = (code == CODE_UNLOCK_ALL) ? 0 : exp_start;
        last  = (code == CODE_UNLOCK_ALL) ? NB - 1 : exp_end;
        b     = first;
        exp_k = 0;
        exp_err = 0;
        while (1) begin
            exp_k++;
            if (b > last) break;
            if (b >= NB) begin exp_err = 1; break; end
            if (exp_st[b] == LS_TIGHT && code != CODE_TIGHT) break;
            if (!(code == CODE_TIGHT && exp_st[b] == LS_UNLOCKED)) begin
                exp_st[b] = t;
                exp_wp    = int'(t);
            end
            if (b == last) break;
            b++;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; start_wr = 0; end_wr = 0; wdata = '0;
        cmd_valid = 0; cmd_code = '0; q_idx = '0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        for (int i = 0; i < NB; i++) exp_st[i] = LS_LOCKED;
        exp_start = 0; exp_end = 0; exp_wp = 2;
    endtask

    task automatic write_start(input logic [15:0] v);
        @(negedge clk) begin start_wr = 1; wdata = v; end
        @(negedge clk) start_wr = 0;
        exp_start = int'(v) % 64;
        exp_end   = exp_start;
    endtask

    task automatic write_end(input logic [15:0] v);
        @(negedge clk) begin end_wr = 1; wdata = v; end
        @(negedge clk) end_wr = 0;
        exp_end = int'(v) % 64;
    endtask

    task automatic check_array(input string req);
        int bad = -1;
        int act = 0;
        int exv = 0;
        for (int i = 0; i < NB; i++) begin
            q_idx = IW'(i);
            #1;
            if (q_state !== exp_st[i] && bad < 0) begin
                bad = i; act = int'(q_state); exv = int'(exp_st[i]);
            end
        end
        chk(bad < 0, req, $sformatf("block %0d state", bad), act, exv);
        q_idx = IW'(50);
        #1;
        chk(q_state == 3'b000, "R12", "query beyond array", int'(q_state), 0);
    endtask

    task automatic run_cmd(input logic [7:0] code, input string req,
                           input bit interfere, input logic [7:0] icode);
        int n;
        model_run(code);
        @(negedge clk) begin cmd_valid = 1; cmd_code = code; end
        @(negedge clk) cmd_valid = 0;
        chk(!cmd_ready, "R10", "cmd_ready low after accept", int'(cmd_ready), 0);
        n = 0;
        while (!done && n < NB + 8) begin
            if (interfere && n == 1) begin cmd_valid = 1; cmd_code = icode; end
            else cmd_valid = 0;
            @(posedge clk);
            n++;
            @(negedge clk);
        end
        cmd_valid = 0;
        chk(n == exp_k, req, "cycles from accept to done (R10)", n, exp_k);
        chk(cmd_err == exp_err, "R7", "cmd_err with done", int'(cmd_err), int'(exp_err));
        @(posedge clk);
        @(negedge clk);
        chk(!done && cmd_ready, "R10", "done single pulse, ready again",
            int'({done, cmd_ready}), 1);
        chk(wp_status == 16'(exp_wp), "R9", "wp_status", int'(wp_status), exp_wp);
        check_array(req);
    endtask

    task automatic ignore_cmd(input logic [7:0] code);
        bit bad = 0;
        @(negedge clk) begin cmd_valid = 1; cmd_code = code; end
        @(negedge clk) cmd_valid = 0;
        repeat (3) begin
            if (done || !cmd_ready) bad = 1;
            @(negedge clk);
        end
        chk(!bad, "R11", "unknown code starts nothing", int'(bad), 0);
        chk(wp_status == 16'(exp_wp), "R11", "wp_status after unknown code",
            int'(wp_status), exp_wp);
        check_array("R11");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL R10 watchdog: actual=hung expected=completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int r;
        logic [7:0] codes [4];
        codes[0] = CODE_UNLOCK; codes[1] = CODE_UNLOCK_ALL;
        codes[2] = CODE_LOCK;   codes[3] = CODE_TIGHT;
        r = int'($urandom(32'd7715));

        do_reset();
        // R1 reset state
        chk(start_blk == 0 && end_blk == 0, "R1", "range regs after reset",
            int'({start_blk, end_blk}), 0);
        chk(wp_status == 16'h0002, "R1", "wp_status after reset", int'(wp_status), 2);
        chk(cmd_ready, "R1", "cmd_ready after reset", int'(cmd_ready), 1);
        check_array("R1");

        // R2 register writes
        write_start(16'h1234);
        chk(start_blk == 6'd52, "R2", "first-block masked", int'(start_blk), 52);
        chk(end_blk == 6'd52, "R2", "last-block copied", int'(end_blk), 52);
        write_end(16'h0005);
        chk(end_blk == 6'd5 && start_blk == 6'd52, "R2", "last-block write only",
            int'({start_blk, end_blk}), (52 << 6) | 5);

        // R8 empty range
        run_cmd(CODE_UNLOCK, "R8", 0, 8'h00);

        write_start(16'd4);  write_end(16'd9);
        run_cmd(CODE_UNLOCK, "R3", 0, 8'h00);
        write_start(16'd2);  write_end(16'd12);
        run_cmd(CODE_TIGHT, "R5", 0, 8'h00);
        write_start(16'd0);  write_end(16'd20);
        run_cmd(CODE_LOCK, "R4", 0, 8'h00);
        run_cmd(CODE_UNLOCK_ALL, "R6", 0, 8'h00);

        do_reset();
        write_start(16'd45); write_end(16'd50);
        run_cmd(CODE_UNLOCK, "R7", 0, 8'h00);
        write_start(16'd0);  write_end(16'd40);
        run_cmd(CODE_TIGHT, "R11", 1, CODE_UNLOCK_ALL);
        ignore_cmd(8'h55);
        ignore_cmd(8'h94);

        do_reset();
        for (int it = 0; it < 80; it++) begin
            r = int'($urandom % 8);
            if (r < 3) write_start(16'($urandom));
            if (r >= 2 && r < 5) write_end(16'($urandom));
            r = int'($urandom % 6);
            if (r < 4) run_cmd(codes[r], "R10", 0, 8'h00);
            else if (r == 4) run_cmd(codes[$urandom % 4], "R3", 1, codes[$urandom % 4]);
            else ignore_cmd(8'($urandom));
            if (it % 20 == 19) do_reset();
        end

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule